// File: doc/BRIEF.md
# Serial Register Transaction Master

This block is the controller end of a low-speed serial link used to read and write 16-bit control registers in a chain of devices. A request port takes one transaction at a time: a read/write select, a 6-bit device number, a broadcast flag, a 12-bit register address and, for writes, 16 bits of data. The master derives a serial clock from the system clock, frames the transaction on a command line and shifts the packets out MSB first on a shared data pin.

A write is four 16-bit packets: request word, address word, data word, then an interval word of zeros. A read sends request, address and interval words, then releases the data pin and receives an 18-bit packet from the chain: a zero, sixteen data bits with bit 15 first, and another zero. The data is presented with a one-cycle `done` pulse; a framing error flag accompanies `done` when either guard bit is seen as 1.

The controller is a state machine with states ST_IDLE, ST_REQ, ST_ADR, ST_DAT, ST_INT, ST_RCV and ST_DONE. Transitions: ST_IDLE to ST_REQ when a request is accepted; ST_REQ to ST_ADR after 16 bits; ST_ADR to ST_DAT (write) or ST_INT (read) after 16 bits; ST_DAT to ST_INT after 16 bits; ST_INT to ST_DONE (write) or ST_RCV (read) after 16 bits; ST_RCV to ST_DONE after 18 bits; ST_DONE to ST_IDLE after one cycle.

Top module: `srt_master`

## Requirements
- R1: With `DIV` the even clock ratio (at least 4), every serial bit lasts `DIV` system cycles; `sck` is high for the first `DIV/2` cycles of the bit and low for the rest, and `sio_out` changes only where a bit begins, so it is stable across each falling edge of `sck`.
- R2: `cmd` is 1 during the first four half-periods of `sck` of the request packet (its first two bits) and 0 in every other cycle.
- R3: The request packet, sent MSB first, is {opcode[3:0], broadcast, device[5:0], 5'b00000} with opcode 4'b0001 for a write and 4'b0010 for a read.
- R4: The address packet, sent MSB first, is {4'b0000, address[11:0]}.
- R5: A write sends request, address, write data and 16 zero bits, 64 bits in total, with `sio_oe` high throughout; `done` is high in the cycle after the last bit.
- R6: A read sends request, address and 16 zero bits with `sio_oe` high, then holds `sio_oe` low (and `sio_out` at 0) for 18 bit periods, sampling `sio_in` in the last system cycle before each falling edge of `sck`; `done` follows the 18th bit.
- R7: After a read, `rd_data` equals received bits 2 to 17, the second received bit being bit 15; it holds until the next read completes and a write does not change it.
- R8: `frame_err` is high exactly in the `done` cycle of a read whose first or last received bit was 1.
- R9: `req_ready` is high only when idle; a request is taken on a clock edge where `req_valid` and `req_ready` are both high, `req_ready` stays low up to and including the `done` cycle, and request inputs seen while busy have no effect.
- R10: While idle and after reset, `sck`, `cmd` and `sio_out` are 0, `sio_oe` is 1 and `rd_data` is 0.
- R11: `done` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Master idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_dev | input | 6 | Target device number |
| req_bcast | input | 1 | Address all devices |
| req_addr | input | 12 | Register address |
| req_wdata | input | 16 | Write data |
| done | output | 1 | Transaction complete pulse |
| rd_data | output | 16 | Last read result |
| frame_err | output | 1 | Guard bit error, valid with done |
| sck | output | 1 | Serial clock |
| cmd | output | 1 | Framing command line |
| sio_out | output | 1 | Serial data driven toward the chain |
| sio_oe | output | 1 | Drive enable for the data pin |
| sio_in | input | 1 | Serial data returned from the chain |

## Verification
Counting from the clock edge that accepts a request, the first request bit appears in the next cycle, bit `b` of the transaction occupies cycles `b*DIV+1` to `b*DIV+DIV` after that edge, and `done` with `rd_data` and `frame_err` is due `64*DIV+1` cycles after it for a write and `66*DIV+1` for a read. The bench keeps a cycle index per transaction, derives every expected pin value from that index, and compares all outputs at each falling system-clock edge. It plays the device by driving `sio_in` from the same index during the receive window, so the sampled bit is settled well before the sampling edge.

// File: rtl/srt_pkg.sv
package srt_pkg;
    localparam int unsigned PKT_W = 16;
    localparam int unsigned DEV_W = 6;
    localparam int unsigned ADR_W = 12;
    localparam int unsigned OP_W  = 4;
    localparam int unsigned RX_W  = PKT_W + 2;
    localparam int unsigned CNT_W = $clog2(RX_W);
    localparam int unsigned BIT_W = $clog2(PKT_W);

    localparam logic [OP_W-1:0] OP_WRITE = 4'b0001;
    localparam logic [OP_W-1:0] OP_READ  = 4'b0010;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_ADR,
        ST_DAT,
        ST_INT,
        ST_RCV,
        ST_DONE
    } srt_state_e;

    function automatic logic [PKT_W-1:0] build_req(
        input logic             wr,
        input logic             bc,
        input logic [DEV_W-1:0] dev
    );
        logic [OP_W-1:0] op;
        op = wr ? OP_WRITE : OP_READ;
        return {op, bc, dev, {(PKT_W-OP_W-1-DEV_W){1'b0}}};
    endfunction

    function automatic logic [PKT_W-1:0] build_adr(input logic [ADR_W-1:0] adr);
        return {{(PKT_W-ADR_W){1'b0}}, adr};
    endfunction
endpackage

// File: rtl/srt_clkdiv.sv
module srt_clkdiv #(
    parameter int unsigned DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic sck_hi,
    output logic fall_tick,
    output logic bit_last
);
    localparam int unsigned PH_W = (DIV > 2) ? $clog2(DIV) : 1;
    localparam int unsigned HALF = DIV / 2;
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(DIV - 1);
    localparam logic [PH_W-1:0] PH_HALF = PH_W'(HALF);
    localparam logic [PH_W-1:0] PH_PRE  = PH_W'(HALF - 1);

    logic [PH_W-1:0] phase_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (!run || phase_q == PH_LAST) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end

    // high half of the bit, then low half
    assign sck_hi    = run && (phase_q < PH_HALF);
    // last cycle before sck falls: the edge ending it is the sample point
    assign fall_tick = run && (phase_q == PH_PRE);
    assign bit_last  = run && (phase_q == PH_LAST);
endmodule

// File: rtl/srt_pktgen.sv
module srt_pktgen
    import srt_pkg::*;
(
    input  srt_state_e       state,
    input  logic             wr,
    input  logic             bc,
    input  logic [DEV_W-1:0] dev,
    input  logic [ADR_W-1:0] adr,
    input  logic [PKT_W-1:0] wdata,
    input  logic [BIT_W-1:0] bit_idx,
    output logic             tx_bit
);
    logic [PKT_W-1:0] word;
    logic [BIT_W-1:0] pos;

    always_comb begin
        unique case (state)
            ST_REQ:  word = build_req(wr, bc, dev);
            ST_ADR:  word = build_adr(adr);
            ST_DAT:  word = wdata;
            default: word = '0;
        endcase
    end

    // MSB first
    assign pos    = BIT_W'(PKT_W - 1) - bit_idx;
    assign tx_bit = word[pos];
endmodule

// File: rtl/srt_rxcap.sv
module srt_rxcap
    import srt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             sample,
    input  logic             sio_in,
    output logic [PKT_W-1:0] word,
    output logic             err
);
    logic [RX_W-1:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else if (clear) begin
            sh_q <= '0;
        end else if (sample) begin
            sh_q <= {sh_q[RX_W-2:0], sio_in};
        end
    end

    assign word = sh_q[RX_W-2:1];
    assign err  = sh_q[RX_W-1] | sh_q[0];
endmodule

// File: rtl/srt_master.sv
module srt_master
    import srt_pkg::*;
#(
    parameter int unsigned DIV = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_write,
    input  logic [DEV_W-1:0] req_dev,
    input  logic             req_bcast,
    input  logic [ADR_W-1:0] req_addr,
    input  logic [PKT_W-1:0] req_wdata,
    output logic             done,
    output logic [PKT_W-1:0] rd_data,
    output logic             frame_err,
    output logic             sck,
    output logic             cmd,
    output logic             sio_out,
    output logic             sio_oe,
    input  logic             sio_in
);
    localparam logic [CNT_W-1:0] PKT_END = CNT_W'(PKT_W - 1);
    localparam logic [CNT_W-1:0] RX_END  = CNT_W'(RX_W - 1);
    localparam logic [CNT_W:0]   CMD_HALVES = (CNT_W+1)'(4);

    srt_state_e       state_q, state_d;
    logic [CNT_W-1:0] bit_q;
    logic             wr_q, bc_q;
    logic [DEV_W-1:0] dev_q;
    logic [ADR_W-1:0] adr_q;
    logic [PKT_W-1:0] dat_q;
    logic [PKT_W-1:0] rd_q;
    logic             err_q;

    logic             run, sck_hi, fall_tick, bit_last;
    logic             accept, pkt_end, rx_end;
    logic             tx_bit;
    logic [PKT_W-1:0] rx_word;
    logic             rx_err;
    logic [CNT_W:0]   half_idx;

    assign run     = (state_q != ST_IDLE) && (state_q != ST_DONE);
    assign accept  = (state_q == ST_IDLE) && req_valid;
    assign pkt_end = bit_last && (bit_q == PKT_END);
    assign rx_end  = bit_last && (bit_q == RX_END);

    srt_clkdiv #(.DIV(DIV)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .sck_hi    (sck_hi),
        .fall_tick (fall_tick),
        .bit_last  (bit_last)
    );

    srt_pktgen u_tx (
        .state   (state_q),
        .wr      (wr_q),
        .bc      (bc_q),
        .dev     (dev_q),
        .adr     (adr_q),
        .wdata   (dat_q),
        .bit_idx (bit_q[BIT_W-1:0]),
        .tx_bit  (tx_bit)
    );

    srt_rxcap u_rx (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (accept),
        .sample (fall_tick && (state_q == ST_RCV)),
        .sio_in (sio_in),
        .word   (rx_word),
        .err    (rx_err)
    );

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid) state_d = ST_REQ;
            ST_REQ:  if (pkt_end)   state_d = ST_ADR;
            ST_ADR:  if (pkt_end)   state_d = wr_q ? ST_DAT : ST_INT;
            ST_DAT:  if (pkt_end)   state_d = ST_INT;
            ST_INT:  if (pkt_end)   state_d = wr_q ? ST_DONE : ST_RCV;
            ST_RCV:  if (rx_end)    state_d = ST_DONE;
            ST_DONE:                state_d = ST_IDLE;
            default:                state_d = ST_IDLE;
        endcase
    end

    // state register and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            bit_q   <= '0;
            wr_q    <= 1'b0;
            bc_q    <= 1'b0;
            dev_q   <= '0;
            adr_q   <= '0;
            dat_q   <= '0;
            rd_q    <= '0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_d != state_q) begin
                bit_q <= '0;
            end else if (bit_last) begin
                bit_q <= bit_q + 1'b1;
            end
            if (accept) begin
                wr_q  <= req_write;
                bc_q  <= req_bcast;
                dev_q <= req_dev;
                adr_q <= req_addr;
                dat_q <= req_wdata;
                err_q <= 1'b0;
            end
            if ((state_q == ST_RCV) && rx_end) begin
                rd_q  <= rx_word;
                err_q <= rx_err;
            end
        end
    end

    // command pattern advances per half-period of sck
    assign half_idx = {bit_q, ~sck_hi};

    // outputs
    always_comb begin
        req_ready = 1'b0;
        done      = 1'b0;
        frame_err = 1'b0;
        sck       = 1'b0;
        cmd       = 1'b0;
        sio_out   = 1'b0;
        sio_oe    = 1'b1;
        unique case (state_q)
            ST_IDLE: req_ready = 1'b1;
            ST_REQ: begin
                sck     = sck_hi;
                sio_out = tx_bit;
                cmd     = (half_idx < CMD_HALVES);
            end
            ST_ADR, ST_DAT, ST_INT: begin
                sck     = sck_hi;
                sio_out = tx_bit;
            end
            ST_RCV: begin
                sck    = sck_hi;
                sio_oe = 1'b0;
            end
            ST_DONE: begin
                done      = 1'b1;
                frame_err = err_q;
            end
            default: req_ready = 1'b0;
        endcase
    end

    assign rd_data = rd_q;
endmodule

// File: rtl/srt_master_chk.sv
module srt_master_chk (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic req_ready,
    input logic done,
    input logic frame_err,
    input logic sck,
    input logic cmd,
    input logic sio_out,
    input logic sio_oe
);
    // R1: data holds while the serial clock stays high
    p_stable_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (sck && $past(sck)) |-> $stable(sio_out));

    // R2: framing only during an active transaction with the pin driven
    p_cmd_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd |-> (!req_ready && sio_oe && !done));

    // R6: released pin only while busy, nothing driven on it
    p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !sio_oe |-> (!req_ready && !cmd && !sio_out && !done));

    // R8: error flag only alongside completion
    p_err_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |-> done);

    // R9: acceptance drops ready
    p_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R9: ready is low on the completion cycle
    p_done_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !req_ready);

    // R10: idle lines are quiet
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!sck && !cmd && sio_oe && !sio_out && !done));

    // R11: single-cycle completion pulse
    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

bind srt_master srt_master_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .done      (done),
    .frame_err (frame_err),
    .sck       (sck),
    .cmd       (cmd),
    .sio_out   (sio_out),
    .sio_oe    (sio_oe)
);

// File: tb/srt_master_tb.sv
`timescale 1ns/1ps
module srt_master_tb;
    localparam int DIV  = 6;
    localparam int HALF = DIV / 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [5:0]  req_dev = '0;
    logic        req_bcast = 1'b0;
    logic [11:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        done;
    logic [15:0] rd_data;
    logic        frame_err;
    logic        sck, cmd, sio_out, sio_oe;
    logic        sio_in = 1'b1;

    always #4 clk = ~clk;

    srt_master #(.DIV(DIV)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_dev(req_dev), .req_bcast(req_bcast),
        .req_addr(req_addr), .req_wdata(req_wdata), .done(done), .rd_data(rd_data),
        .frame_err(frame_err), .sck(sck), .cmd(cmd), .sio_out(sio_out),
        .sio_oe(sio_oe), .sio_in(sio_in)
    );

    int   errors = 0;
    int   checks = 0;
    bit   finished = 0;
    bit   model_on = 0;

    // reference model state
    bit          busy = 0;
    int          t = 0;
    int          nbits = 0;
    bit          m_wr;
    logic [63:0] m_stream;
    logic [17:0] m_resp;
    logic [17:0] next_resp = '0;
    logic [15:0] exp_rd = '0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s at %0t: actual=%0h expected=%0h", req, what, $time, act, exp);
        end
    endtask

    task automatic chk_idle(input string tag);
        chk(req_ready === 1'b1, "R9", {tag, " ready"}, 32'(req_ready), 1);
        chk(sck === 1'b0 && cmd === 1'b0, "R10", {tag, " sck/cmd"}, {sck, cmd}, 0);
        chk(sio_oe === 1'b1 && sio_out === 1'b0, "R10", {tag, " sio"}, {sio_oe, sio_out}, 2);
        chk(done === 1'b0 && frame_err === 1'b0, "R11", {tag, " done/err"}, {done, frame_err}, 0);
        chk(rd_data === exp_rd, "R7", {tag, " rd_data held"}, 32'(rd_data), 32'(exp_rd));
    endtask

    // cycle-by-cycle comparison and model advance
    always @(negedge clk) begin
        if (rst_n && model_on) begin
            if (!busy) begin
                sio_in = 1'b1;
                chk_idle("idle");
            end else if (t < nbits * DIV) begin
                int b;
                int ph;
                bit rcv;
                b   = t / DIV;
                ph  = t % DIV;
                rcv = !m_wr && (b >= 48);
                sio_in = rcv ? m_resp[17 - (b - 48)] : 1'b1;
                chk(req_ready === 1'b0, "R9", "ready while busy", 32'(req_ready), 0);
                chk(done === 1'b0, "R11", "done early", 32'(done), 0);
                chk(sck === (ph < HALF), "R1", "sck phase", 32'(sck), 32'(ph < HALF));
                chk(cmd === (b < 2), "R2", "cmd frame", 32'(cmd), 32'(b < 2));
                if (rcv) begin
                    chk(sio_oe === 1'b0 && sio_out === 1'b0, "R6", "pin released",
                        {sio_oe, sio_out}, 0);
                end else begin
                    chk(sio_oe === 1'b1, m_wr ? "R5" : "R6", "pin driven", 32'(sio_oe), 1);
                    chk(sio_out === m_stream[63 - b], b < 16 ? "R3" : (b < 32 ? "R4" : (m_wr ? "R5" : "R6")),
                        "serial bit", 32'(sio_out), 32'(m_stream[63 - b]));
                end
            end else begin
                sio_in = 1'b1;
                if (!m_wr) exp_rd = m_resp[16:1];
                chk(done === 1'b1, m_wr ? "R5" : "R6", "done due", 32'(done), 1);
                chk(req_ready === 1'b0, "R9", "ready at done", 32'(req_ready), 0);
                chk(rd_data === exp_rd, "R7", "rd_data", 32'(rd_data), 32'(exp_rd));
                chk(frame_err === (!m_wr && (m_resp[17] | m_resp[0])), "R8", "frame_err",
                    32'(frame_err), 32'(!m_wr && (m_resp[17] | m_resp[0])));
                chk(sck === 1'b0 && cmd === 1'b0 && sio_oe === 1'b1, "R10", "lines at done",
                    {sck, cmd, sio_oe}, 1);
            end
            // advance to the next cycle
            if (busy) begin
                t++;
                if (t > nbits * DIV) busy = 0;
            end else if (req_valid) begin
                logic [15:0] rq;
                busy  = 1;
                t     = 0;
                m_wr  = req_write;
                m_resp = next_resp;
                nbits = req_write ? 64 : 66;
                rq = {req_write ? 4'b0001 : 4'b0010, req_bcast, req_dev, 5'b00000};
                m_stream = {rq, 4'b0000, req_addr, req_write ? req_wdata : 16'h0000, 16'h0000};
            end
        end
    end

    task automatic issue(input bit wr, input logic [5:0] dev, input bit bc,
                         input logic [11:0] adr, input logic [15:0] wd,
                         input logic [17:0] resp);
        @(posedge clk); #1;
        next_resp = resp;
        req_write = wr; req_dev = dev; req_bcast = bc; req_addr = adr; req_wdata = wd;
        req_valid = 1'b1;
        forever begin
            @(negedge clk);
            if (req_ready) break;
        end
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        // reset state (R10)
        repeat (3) @(negedge clk);
        chk_idle("reset");
        @(posedge clk); #1;
        rst_n = 1'b1;
        model_on = 1;
        repeat (3) @(posedge clk);

        // R5 R3 R4: unicast write
        issue(1, 6'h15, 0, 12'hA5C, 16'hBEEF, '0);
        wait_idle();
        // R5 R3: broadcast write, extreme fields
        issue(1, 6'h3F, 1, 12'hFFF, 16'h8001, '0);
        wait_idle();
        // R6 R7: read with clean guard bits
        issue(0, 6'h01, 0, 12'h123, 16'hFFFF, {1'b0, 16'hC3A5, 1'b0});
        wait_idle();
        // R7: write leaves rd_data unchanged
        issue(1, 6'h2A, 0, 12'h800, 16'h0000, '0);
        wait_idle();
        // R8: bad leading guard bit
        issue(0, 6'h00, 1, 12'h001, 16'h0000, {1'b1, 16'h5A5A, 1'b0});
        wait_idle();
        // R8: bad trailing guard bit
        issue(0, 6'h10, 0, 12'h7FE, 16'h0000, {1'b0, 16'h0001, 1'b1});
        wait_idle();
        // R9: second request held while first is busy, then back to back
        issue(0, 6'h05, 0, 12'h0F0, 16'h0000, {1'b0, 16'h8000, 1'b0});
        issue(1, 6'h22, 1, 12'h00F, 16'h1234, '0);
        wait_idle();
        // R7 R8: all-ones data with clean guards
        issue(0, 6'h3E, 0, 12'hABC, 16'h0000, {1'b0, 16'hFFFF, 1'b0});
        wait_idle();
        finish_run();
    end
endmodule